// File: doc/BRIEF.md
# Host-to-Controller Register Transfer Bridge

This block lets a host processor reach the 16-bit internal registers of a network controller through a memory-mapped window of byte registers. The host stages a word in two write byte latches. It selects the direction and the target through a control register. A write of any value to the command location then starts a transfer. The bridge drives a small register bus toward the controller with a target select, a read/write line and a strobe. On a read, it captures the returned word into two separate read byte latches.

Status and control share one host address. A read there returns the status byte and a write there loads the control byte. Status reports a busy flag while a transfer is running and an active-low copy of the controller's interrupt line. Control also holds a board-reset bit that keeps the controller in reset while it is clear.

Host map with default parameters: offset 0 is the low byte and offset 1 the high byte (write latches on a write, read latches on a read). Offset 2 is status (read) or control (write). Offset 3 is the command location, which reads as 0x00.

Top module: `regXferBridge`

## Requirements
- R1: After reset, status reads 0x10, both read latches read 0x00, `ctlReset` is 1 (the control byte resets to 0x00) and `ctlStrobe` is 0.
- R2: Host writes to offsets 0 and 1 load the low and high bytes of the write word. During a write transfer, `ctlWrData` presents {high, low}.
- R3: When control bit 3 is 1 and no transfer is running, a host write of any value to offset 3 starts a transfer on the next clock. `ctlStrobe` is then high for exactly 4 consecutive cycles, and status bit 5 reads 1 during the transfer and 0 once it ends.
- R4: Control bit 1 selects direction: 0 writes to the controller, giving `ctlWrite`=1, and 1 reads from it. Control bit 0 selects the target: 1 is the address port, giving `ctlSel`=1, and 0 is the data port. Both values are sampled when a transfer starts and stay fixed until it ends, even if control is rewritten meanwhile.
- R5: On a read transfer, the read latches take `ctlRdData` at the clock edge that ends the strobe. Offsets 0 and 1 then return its low and high bytes, whatever the write latches hold.
- R6: A command write that arrives while a transfer is running is ignored. The running transfer keeps its length and no second transfer follows.
- R7: Host writes to offsets 0 and 1 while a transfer is running are ignored, so the write word keeps its value.
- R8: While control bit 3 is 0, `ctlReset` is 1. A running transfer is abandoned one cycle after the bit is cleared, so busy and strobe drop, and command writes start nothing.
- R9: Status bit 4 is the inverse of `ctlIrq`, delayed by a two-flop synchronizer. After `ctlIrq` changes, the bit follows on the second clock edge and not on the first.
- R10: Status bits 7:6 and 3:0 read 0, and offset 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hostWr | input | 1 | Host write enable for one cycle |
| hostAddr | input | 3 | Host register offset |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, combinational on `hostAddr` |
| ctlSel | output | 1 | Controller target: 1 address port, 0 data port |
| ctlWrite | output | 1 | Controller direction: 1 write, 0 read |
| ctlStrobe | output | 1 | Controller access strobe |
| ctlWrData | output | 16 | Word driven to the controller |
| ctlRdData | input | 16 | Word returned by the controller |
| ctlIrq | input | 1 | Controller interrupt request, active high, asynchronous |
| ctlReset | output | 1 | Controller reset, active high |

## Verification
The hardest conditions to reach from the ports are host accesses that land inside the four-cycle transfer window. These are a second command, a rewrite of control and a rewrite of a write latch. Each host access takes a full clock, so the bench issues them back to back right after the launching command. It counts the strobe cycles that remain, to prove that the running transfer kept its length, direction and data. Clearing the board-reset bit in the middle of a transfer is reached the same way, and the bench then checks that the strobe drops on the following cycle.

// File: rtl/regBridgePkg.sv
package regBridgePkg;
  typedef struct packed {
    logic launch;
    logic finish;
  } xferStrb_t;

  localparam int CTRL_TGT_BIT  = 0;
  localparam int CTRL_DIR_BIT  = 1;
  localparam int CTRL_RUN_BIT  = 3;
  localparam int STAT_IRQN_BIT = 4;
  localparam int STAT_BUSY_BIT = 5;
endpackage

// File: rtl/regBridgeCtrl.sv
module regBridgeCtrl
  import regBridgePkg::*;
#(
  parameter int STROBE_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmdReq,
  input  logic      boardRst,
  output xferStrb_t strb,
  output logic      busy
);
  localparam int CNT_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYCLES - 1);

  typedef enum logic [0:0] {IDLE, RUN} state_t;
  state_t state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strb.launch = (state == IDLE) && cmdReq && !boardRst;
    strb.finish = (state == RUN) && (cnt == LAST) && !boardRst;
  end

  always_ff @(posedge clk) begin
    if (rst || boardRst) begin
      state <= IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        IDLE: if (strb.launch) begin
          state <= RUN;
          cnt   <= '0;
        end
        RUN: begin
          if (strb.finish) state <= IDLE;
          cnt <= cnt + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy = (state == RUN);

  // Length of the current busy run, used only by the checks below.
  logic [15:0] runLen;
  always_ff @(posedge clk) begin
    if (rst || !busy) runLen <= '0;
    else              runLen <= runLen + 1'b1;
  end

  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(boardRst)) |-> ($past(runLen) == 16'(STROBE_CYCLES - 1)));

  // R6
  launch_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(cmdReq) && !$past(boardRst)));
endmodule

// File: rtl/regBridgeDatapath.sv
module regBridgeDatapath
  import regBridgePkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  input  xferStrb_t         strb,
  input  logic              busy,
  output logic              cmdReq,
  output logic              boardRst,
  output logic              ctlSel,
  output logic              ctlWrite,
  output logic [WORD_W-1:0] ctlWrData,
  input  logic [WORD_W-1:0] ctlRdData,
  input  logic              ctlIrq,
  output logic              ctlReset
);
  localparam int NUM_LANES = WORD_W / 8;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_LANES);
  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(NUM_LANES + 1);

  logic [WORD_W-1:0] wrLatch, rdLatch;
  logic runBit, dirBit, tgtBit;
  logic snapRead, snapAddrPort;
  logic [1:0] irqSync;

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : gLane
      always_ff @(posedge clk) begin
        if (rst) wrLatch[g*8 +: 8] <= '0;
        else if (hostWr && hostAddr == ADDR_W'(g) && !busy)
          wrLatch[g*8 +: 8] <= hostWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                          rdLatch <= '0;
    else if (strb.finish && snapRead) rdLatch <= ctlRdData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runBit <= 1'b0;
      dirBit <= 1'b0;
      tgtBit <= 1'b0;
    end else if (hostWr && hostAddr == STAT_ADDR) begin
      runBit <= hostWrData[CTRL_RUN_BIT];
      dirBit <= hostWrData[CTRL_DIR_BIT];
      tgtBit <= hostWrData[CTRL_TGT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snapRead     <= 1'b0;
      snapAddrPort <= 1'b0;
    end else if (strb.launch) begin
      snapRead     <= dirBit;
      snapAddrPort <= tgtBit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irqSync <= '0;
    else     irqSync <= {irqSync[0], ctlIrq};
  end

  always_comb begin
    hostRdData = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (hostAddr == ADDR_W'(i)) hostRdData = rdLatch[i*8 +: 8];
    if (hostAddr == STAT_ADDR) begin
      hostRdData[STAT_BUSY_BIT] = busy;
      hostRdData[STAT_IRQN_BIT] = ~irqSync[1];
    end
  end

  assign cmdReq    = hostWr && (hostAddr == CMD_ADDR);
  assign boardRst  = ~runBit;
  assign ctlReset  = ~runBit;
  assign ctlSel    = snapAddrPort;
  assign ctlWrite  = ~snapRead;
  assign ctlWrData = wrLatch;

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(ctlWrite) && $stable(ctlSel)));

  // R7
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ctlWrData));

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ctlReset |=> !busy);

  // R5
  rdlatch_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdLatch) |-> ($past(strb.finish) && !$past(ctlWrite)));
endmodule

// File: rtl/regXferBridge.sv
module regXferBridge
  import regBridgePkg::*;
#(
  parameter int WORD_W        = 16,
  parameter int ADDR_W        = 3,
  parameter int STROBE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  output logic              ctlSel,
  output logic              ctlWrite,
  output logic              ctlStrobe,
  output logic [WORD_W-1:0] ctlWrData,
  input  logic [WORD_W-1:0] ctlRdData,
  input  logic              ctlIrq,
  output logic              ctlReset
);
  xferStrb_t strb;
  logic busy, cmdReq, boardRst;

  regBridgeCtrl #(.STROBE_CYCLES(STROBE_CYCLES)) uCtrl (
    .clk(clk), .rst(rst), .cmdReq(cmdReq), .boardRst(boardRst),
    .strb(strb), .busy(busy)
  );

  regBridgeDatapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rst(rst), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .strb(strb),
    .busy(busy), .cmdReq(cmdReq), .boardRst(boardRst), .ctlSel(ctlSel),
    .ctlWrite(ctlWrite), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .ctlIrq(ctlIrq), .ctlReset(ctlReset)
  );

  assign ctlStrobe = busy;
endmodule

// File: tb/tb_regXferBridge.sv
`timescale 1ns/1ps
module tb_regXferBridge;
  logic clk = 1'b0;
  logic rst;
  logic hostWr;
  logic [2:0] hostAddr;
  logic [7:0] hostWrData, hostRdData;
  logic ctlSel, ctlWrite, ctlStrobe, ctlIrq, ctlReset;
  logic [15:0] ctlWrData, ctlRdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  regXferBridge dut (
    .clk(clk), .rst(rst), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .ctlSel(ctlSel),
    .ctlWrite(ctlWrite), .ctlStrobe(ctlStrobe), .ctlWrData(ctlWrData),
    .ctlRdData(ctlRdData), .ctlIrq(ctlIrq), .ctlReset(ctlReset)
  );

  // Controller stub: an address port and four data registers.
  logic [1:0]  stubRap;
  logic [15:0] stubRegs [4];
  logic        stubSeen;
  always @(posedge clk) begin
    if (rst) begin
      stubRap <= '0;
      stubSeen <= 1'b0;
      for (int i = 0; i < 4; i++) stubRegs[i] <= '0;
    end else begin
      if (ctlStrobe && !stubSeen && ctlWrite) begin
        if (ctlSel) stubRap <= ctlWrData[1:0];
        else        stubRegs[stubRap] <= ctlWrData;
      end
      stubSeen <= ctlStrobe;
    end
  end
  assign ctlRdData = ctlSel ? {14'd0, stubRap} : stubRegs[stubRap];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [7:0] d);
    hostWr = 1'b1; hostAddr = a; hostWrData = d;
    @(posedge clk); @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [7:0] d);
    hostAddr = a; #1; d = hostRdData;
  endtask

  task automatic countStrobe(output int n);
    n = 0;
    while (ctlStrobe && n < 20) begin n++; @(negedge clk); end
  endtask

  task automatic runXfer(input logic [7:0] ctrl, input logic [7:0] lo, input logic [7:0] hi);
    int n;
    logic [7:0] s;
    hostWrite(3'd0, lo);
    hostWrite(3'd1, hi);
    hostWrite(3'd2, ctrl);
    hostWrite(3'd3, 8'h5A);
    hostRead(3'd2, s);
    chk(s[5] == 1'b1, "R3 busy during transfer", s, 8'h20);
    chk(ctlWrite == !ctrl[1], "R4 direction", ctlWrite, !ctrl[1]);
    chk(ctlSel == ctrl[0], "R4 target", ctlSel, ctrl[0]);
    if (!ctrl[1]) chk(ctlWrData == {hi, lo}, "R2 write word", ctlWrData, {hi, lo});
    countStrobe(n);
    chk(n == 4, "R3 strobe length", n, 4);
    hostRead(3'd2, s);
    chk(s[5] == 1'b0, "R3 busy cleared", s, 0);
  endtask

  task automatic testReset();
    logic [7:0] d;
    hostRead(3'd2, d); chk(d == 8'h10, "R1 status", d, 8'h10);
    hostRead(3'd0, d); chk(d == 8'h00, "R1 read low", d, 0);
    hostRead(3'd1, d); chk(d == 8'h00, "R1 read high", d, 0);
    chk(ctlReset == 1'b1, "R1 ctlReset", ctlReset, 1);
    chk(ctlStrobe == 1'b0, "R1 strobe", ctlStrobe, 0);
    hostRead(3'd3, d); chk(d == 8'h00, "R10 command reads zero", d, 0);
  endtask

  task automatic testWriteRead();
    logic [7:0] d;
    hostWrite(3'd2, 8'h08);
    chk(ctlReset == 1'b0, "R8 reset released", ctlReset, 0);
    runXfer(8'h09, 8'h02, 8'h00);
    chk(stubRap == 2'd2, "R4 address port written", stubRap, 2);
    runXfer(8'h08, 8'hEF, 8'hBE);
    chk(stubRegs[2] == 16'hBEEF, "R2 data port written", stubRegs[2], 16'hBEEF);
    runXfer(8'h0A, 8'h34, 8'h12);
    hostRead(3'd0, d); chk(d == 8'hEF, "R5 read low", d, 8'hEF);
    hostRead(3'd1, d); chk(d == 8'hBE, "R5 read high", d, 8'hBE);
    runXfer(8'h0B, 8'h77, 8'h66);
    hostRead(3'd0, d); chk(d == 8'h02, "R5 address port read", d, 2);
    hostRead(3'd2, d); chk((d & 8'hCF) == 8'h00, "R10 status spare bits", d, 0);
  endtask

  task automatic testBusyIgnore();
    int n;
    hostWrite(3'd0, 8'h11);
    hostWrite(3'd1, 8'h22);
    hostWrite(3'd2, 8'h08);
    hostWrite(3'd3, 8'h00);
    hostWrite(3'd3, 8'hFF);
    hostWrite(3'd2, 8'h0B);
    hostWrite(3'd0, 8'h99);
    chk(ctlWrite == 1'b1, "R4 held after control rewrite", ctlWrite, 1);
    chk(ctlWrData == 16'h2211, "R7 latch write ignored", ctlWrData, 16'h2211);
    countStrobe(n);
    chk(n == 1, "R6 remaining strobe cycles", n, 1);
    n = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (ctlStrobe) n++; end
    chk(n == 0, "R6 no second transfer", n, 0);
    chk(stubRegs[2] == 16'h2211, "R7 controller got held word", stubRegs[2], 16'h2211);
    hostWrite(3'd2, 8'h08);
    hostWrite(3'd3, 8'h01);
    chk(ctlWrData == 16'h2211, "R7 low byte kept", ctlWrData, 16'h2211);
    countStrobe(n);
  endtask

  task automatic testBoardReset();
    int n;
    logic [7:0] d;
    hostWrite(3'd2, 8'h08);
    hostWrite(3'd3, 8'h00);
    hostWrite(3'd2, 8'h00);
    chk(ctlReset == 1'b1, "R8 ctlReset asserted", ctlReset, 1);
    @(negedge clk);
    chk(ctlStrobe == 1'b0, "R8 strobe abandoned", ctlStrobe, 0);
    hostRead(3'd2, d); chk(d[5] == 1'b0, "R8 busy cleared", d, 0);
    hostWrite(3'd3, 8'h00);
    n = 0;
    for (int i = 0; i < 6; i++) begin if (ctlStrobe) n++; @(negedge clk); end
    chk(n == 0, "R8 command ignored in reset", n, 0);
    hostWrite(3'd2, 8'h08);
    chk(ctlReset == 1'b0, "R8 reset released again", ctlReset, 0);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    ctlIrq = 1'b1;
    @(negedge clk);
    hostRead(3'd2, d); chk(d[4] == 1'b1, "R9 one edge not yet", d[4], 1);
    @(negedge clk);
    hostRead(3'd2, d); chk(d[4] == 1'b0, "R9 irq after two edges", d[4], 0);
    ctlIrq = 1'b0;
    @(negedge clk); @(negedge clk);
    hostRead(3'd2, d); chk(d[4] == 1'b1, "R9 irq released", d[4], 1);
  endtask

  initial begin
    rst = 1'b1; hostWr = 1'b0; hostAddr = '0; hostWrData = '0; ctlIrq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testWriteRead();
    testBusyIgnore();
    testBoardReset();
    testIrq();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule